// File: doc/BRIEF.md
# Memory-Type-Aware 64-to-32 Access Splitter

This block connects a requester that issues 64-bit wide requests to a memory side that accepts 32-bit accesses. Each request carries an address, a read/write flag, a size code, eight byte strobes, 64 bits of write data and a memory-type attribute. The memory type decides how a doubleword request is carried. On Normal memory a doubleword can go out as one beat on an optional 64-bit wide path. On Device or Strongly-ordered memory it is broken into two word accesses on the narrow port. The word at the lower address always goes first. The word at the higher address follows only after the first has been answered.

Read halves are put back together into one 64-bit response. An error on any beat is reported on that combined response. Requests of word size or smaller pass through as a single narrow access, whatever their memory type. Only one request is in flight at a time, and both requester channels use valid/ready handshakes.

Top module: `dev_aware_splitter`

## Requirements
- R1: After reset, req_ready is 1, and nar_valid, wid_valid and rsp_valid are all 0.
- R2: A request with size code 0, 1 or 2 (byte, half, word) produces exactly one narrow beat. Its address and size are unchanged. Address bit 2 selects the lane: 0 takes strobes [3:0] and data [31:0], and 1 takes strobes [7:4] and data [63:32].
- R3: A size-3 (doubleword) request with memory type 1 (Device) or 2 (Strongly-ordered) produces exactly two narrow beats of size code 2. The first beat uses the address with bits [2:0] cleared and the low lane. The second uses that address plus 4 and the high lane.
- R4: The second beat of a split request is not presented on the narrow port until the first beat's response (nar_rvalid) has arrived.
- R5: Read data is returned in a single response. For a split request, the lower-address word lands in rsp_rdata[31:0] and the higher-address word in rsp_rdata[63:32]. For a single narrow read, the word lands in the lane chosen by address bit 2 and the other lane is 0.
- R6: rsp_err is the OR of the error flags of all beats of the request. An error on the first half of a split request does not stop the second half from being issued.
- R7: Every narrow beat carries the request's memory type on nar_mtype unchanged (0 Normal, 1 Device, 2 Strongly-ordered), along with its write flag.
- R8: A size-3 request with memory type 0 (Normal) uses one beat on the wide port, with the aligned address and the full strobes and data. It issues no narrow beat, and its response data and error come from the wide response.
- R9: After a request is accepted, req_ready stays 0 until the response is taken. rsp_valid, rsp_rdata and rsp_err hold steady while rsp_ready is 0.
- R10: While nar_valid is 1 and nar_ready is 0, the narrow beat's address, strobes and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | AW | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 doubleword |
| req_strb | input | 8 | Byte strobes |
| req_wdata | input | 64 | Write data |
| req_mtype | input | 2 | Memory type: 0 Normal, 1 Device, 2 Strongly-ordered |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 64 | Assembled read data |
| rsp_err | output | 1 | Error on any beat |
| nar_valid | output | 1 | Narrow beat valid |
| nar_ready | input | 1 | Narrow beat accepted |
| nar_addr | output | AW | Narrow beat address |
| nar_write | output | 1 | Narrow beat write flag |
| nar_size | output | 2 | Narrow beat size code |
| nar_strb | output | 4 | Narrow beat strobes |
| nar_wdata | output | 32 | Narrow beat write data |
| nar_mtype | output | 2 | Narrow beat memory type |
| nar_rvalid | input | 1 | Narrow response valid |
| nar_rdata | input | 32 | Narrow response data |
| nar_err | input | 1 | Narrow response error |
| wid_valid | output | 1 | Wide beat valid |
| wid_ready | input | 1 | Wide beat accepted |
| wid_addr | output | AW | Wide beat aligned address |
| wid_write | output | 1 | Wide beat write flag |
| wid_strb | output | 8 | Wide beat strobes |
| wid_wdata | output | 64 | Wide beat write data |
| wid_rvalid | input | 1 | Wide response valid |
| wid_rdata | input | 64 | Wide response data |
| wid_err | input | 1 | Wide response error |

## Verification
Doubleword requests are sent as Device, as Strongly-ordered and as Normal. The same size code then yields two narrow beats or one wide beat, which shows that the memory type alone picks the path. Reads and writes at word, half and byte size with address bit 2 set and clear check lane selection and show that small requests never split. The error address is placed on the low half, then the high half, then a wide beat, to show that errors are ORed across beats and that a failing first half does not cancel the second. A stalling narrow port and a longer response latency separate a correct wait-for-response ordering from one that issues the high word early.

// File: rtl/wns_pkg.sv
package wns_pkg;
  localparam logic [1:0] MT_NORMAL = 2'd0;
  localparam logic [1:0] MT_DEVICE = 2'd1;
  localparam logic [1:0] MT_STRONG = 2'd2;
  localparam logic [1:0] SZ_WORD   = 2'd2;
  localparam logic [1:0] SZ_DWORD  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_NISSUE, ST_NWAIT, ST_WISSUE, ST_WWAIT, ST_RESP
  } state_e;

  // A doubleword request leaves on the narrow port unless the wide path is
  // present and the memory type allows merging.
  function automatic logic goes_wide(logic [1:0] size, logic [1:0] mtype, logic wide_en);
    return wide_en && size == SZ_DWORD && mtype == MT_NORMAL;
  endfunction

  function automatic logic goes_split(logic [1:0] size, logic [1:0] mtype, logic wide_en);
    return size == SZ_DWORD && !goes_wide(size, mtype, wide_en);
  endfunction
endpackage

// File: rtl/wns_lane.sv
module wns_lane
  import wns_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic [7:0]    strb,
  input  logic [63:0]   wdata,
  input  logic          split,
  input  logic          hi,
  output logic [AW-1:0] n_addr,
  output logic [1:0]    n_size,
  output logic [3:0]    n_strb,
  output logic [31:0]   n_wdata
);
  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] a, logic sp, logic h);
    return sp ? {a[AW-1:3], h, 2'b00} : a;
  endfunction

  assign n_addr  = beat_addr(addr, split, hi);
  assign n_size  = split ? SZ_WORD : size;
  assign n_strb  = hi ? strb[7:4] : strb[3:0];
  assign n_wdata = hi ? wdata[63:32] : wdata[31:0];
endmodule

// File: rtl/wns_rdmerge.sv
module wns_rdmerge (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        nar_ld,
  input  logic        hi,
  input  logic [31:0] nar_din,
  input  logic        nar_err,
  input  logic        wid_ld,
  input  logic [63:0] wid_din,
  input  logic        wid_err,
  output logic [63:0] data,
  output logic        err
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      data <= '0;
      err  <= 1'b0;
    end else if (wid_ld) begin
      data <= wid_din;
      err  <= wid_err;
    end else if (nar_ld) begin
      if (hi) data[63:32] <= nar_din;
      else    data[31:0]  <= nar_din;
      err <= err | nar_err;
    end
  end
endmodule

// File: rtl/wns_ctrl.sv
module wns_ctrl
  import wns_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic use_wide,
  input  logic use_split,
  input  logic start_hi,
  input  logic nar_ready,
  input  logic nar_rvalid,
  input  logic wid_ready,
  input  logic wid_rvalid,
  input  logic rsp_ready,
  output logic req_ready,
  output logic nar_valid,
  output logic wid_valid,
  output logic rsp_valid,
  output logic hi_sel,
  output logic split_sel,
  output logic ev_accept,
  output logic ev_nar_done,
  output logic ev_wid_done
);
  state_e st_q;
  logic   hi_q, split_q, pend_q, lo_done_q;
  logic   ev_nar_fire;

  function automatic state_e after_beat(logic sp, logic h);
    return (sp && !h) ? ST_NISSUE : ST_RESP;
  endfunction

  assign req_ready   = st_q == ST_IDLE;
  assign nar_valid   = st_q == ST_NISSUE;
  assign wid_valid   = st_q == ST_WISSUE;
  assign rsp_valid   = st_q == ST_RESP;
  assign ev_accept   = req_valid && req_ready;
  assign ev_nar_fire = nar_valid && nar_ready;
  assign ev_nar_done = st_q == ST_NWAIT && nar_rvalid;
  assign ev_wid_done = st_q == ST_WWAIT && wid_rvalid;
  assign hi_sel      = hi_q;
  assign split_sel   = split_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      hi_q      <= 1'b0;
      split_q   <= 1'b0;
      lo_done_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (ev_accept) begin
          split_q   <= use_split;
          hi_q      <= use_split ? 1'b0 : start_hi;
          lo_done_q <= 1'b0;
          st_q      <= use_wide ? ST_WISSUE : ST_NISSUE;
        end
        ST_NISSUE: if (nar_ready) st_q <= ST_NWAIT;
        ST_NWAIT: if (nar_rvalid) begin
          st_q <= after_beat(split_q, hi_q);
          if (split_q && !hi_q) begin
            hi_q      <= 1'b1;
            lo_done_q <= 1'b1;
          end
        end
        ST_WISSUE: if (wid_ready) st_q <= ST_WWAIT;
        ST_WWAIT:  if (wid_rvalid) st_q <= ST_RESP;
        ST_RESP:   if (rsp_ready) st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  // Tracks a narrow beat that was handed over but not yet answered.
  always_ff @(posedge clk) begin
    if (!rst_n)           pend_q <= 1'b0;
    else if (ev_nar_fire) pend_q <= 1'b1;
    else if (nar_rvalid)  pend_q <= 1'b0;
  end

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nar_valid |-> !pend_q);
  assert_low_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_nar_fire && split_q && hi_q) |-> lo_done_q);
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid);
endmodule

// File: rtl/dev_aware_splitter.sv
module dev_aware_splitter
  import wns_pkg::*;
#(
  parameter int AW      = 32,
  parameter bit WIDE_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [7:0]    req_strb,
  input  logic [63:0]   req_wdata,
  input  logic [1:0]    req_mtype,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [63:0]   rsp_rdata,
  output logic          rsp_err,
  output logic          nar_valid,
  input  logic          nar_ready,
  output logic [AW-1:0] nar_addr,
  output logic          nar_write,
  output logic [1:0]    nar_size,
  output logic [3:0]    nar_strb,
  output logic [31:0]   nar_wdata,
  output logic [1:0]    nar_mtype,
  input  logic          nar_rvalid,
  input  logic [31:0]   nar_rdata,
  input  logic          nar_err,
  output logic          wid_valid,
  input  logic          wid_ready,
  output logic [AW-1:0] wid_addr,
  output logic          wid_write,
  output logic [7:0]    wid_strb,
  output logic [63:0]   wid_wdata,
  input  logic          wid_rvalid,
  input  logic [63:0]   wid_rdata,
  input  logic          wid_err
);
  logic [AW-1:0] addr_q;
  logic          write_q;
  logic [1:0]    size_q, mtype_q;
  logic [7:0]    strb_q;
  logic [63:0]   wdata_q;
  logic          use_wide, use_split;
  logic          hi_sel, split_sel, ev_accept, ev_nar_done, ev_wid_done;

  generate
    if (WIDE_EN) begin : g_wide
      assign use_wide = goes_wide(req_size, req_mtype, 1'b1);
    end else begin : g_narrow_only
      assign use_wide = 1'b0;
    end
  endgenerate
  assign use_split = goes_split(req_size, req_mtype, WIDE_EN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      size_q  <= '0;
      mtype_q <= MT_NORMAL;
      strb_q  <= '0;
      wdata_q <= '0;
    end else if (ev_accept) begin
      addr_q  <= req_addr;
      write_q <= req_write;
      size_q  <= req_size;
      mtype_q <= req_mtype;
      strb_q  <= req_strb;
      wdata_q <= req_wdata;
    end
  end

  wns_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .use_wide(use_wide), .use_split(use_split), .start_hi(req_addr[2]),
    .nar_ready(nar_ready), .nar_rvalid(nar_rvalid),
    .wid_ready(wid_ready), .wid_rvalid(wid_rvalid), .rsp_ready(rsp_ready),
    .req_ready(req_ready), .nar_valid(nar_valid), .wid_valid(wid_valid),
    .rsp_valid(rsp_valid), .hi_sel(hi_sel), .split_sel(split_sel),
    .ev_accept(ev_accept), .ev_nar_done(ev_nar_done), .ev_wid_done(ev_wid_done)
  );

  wns_lane #(.AW(AW)) u_lane (
    .addr(addr_q), .size(size_q), .strb(strb_q), .wdata(wdata_q),
    .split(split_sel), .hi(hi_sel),
    .n_addr(nar_addr), .n_size(nar_size), .n_strb(nar_strb), .n_wdata(nar_wdata)
  );

  wns_rdmerge u_merge (
    .clk(clk), .rst_n(rst_n), .clr(ev_accept),
    .nar_ld(ev_nar_done), .hi(hi_sel), .nar_din(nar_rdata), .nar_err(nar_err),
    .wid_ld(ev_wid_done), .wid_din(wid_rdata), .wid_err(wid_err),
    .data(rsp_rdata), .err(rsp_err)
  );

  assign nar_write = write_q;
  assign nar_mtype = mtype_q;
  assign wid_addr  = {addr_q[AW-1:3], 3'b000};
  assign wid_write = write_q;
  assign wid_strb  = strb_q;
  assign wid_wdata = wdata_q;

  assert_beat_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (nar_valid && !nar_ready) |=> nar_valid && $stable(nar_addr)
                                  && $stable(nar_strb) && $stable(nar_wdata));
  assert_wide_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wid_valid |-> (mtype_q == MT_NORMAL && size_q == SZ_DWORD));
  assert_rsp_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> $stable(rsp_rdata) && $stable(rsp_err));
  assert_one_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, nar_valid, wid_valid, rsp_valid}));
endmodule

// File: tb/dev_aware_splitter_test.sv
module dev_aware_splitter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [31:0] req_addr = 0;
  logic [1:0]  req_size = 0, req_mtype = 0;
  logic [7:0]  req_strb = 0;
  logic [63:0] req_wdata = 0;
  logic req_ready, rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic nar_valid, nar_write, wid_valid, wid_write;
  logic [31:0] nar_addr, nar_wdata, wid_addr;
  logic [1:0]  nar_size, nar_mtype;
  logic [3:0]  nar_strb;
  logic [7:0]  wid_strb;
  logic [63:0] wid_wdata;
  logic nar_ready = 1, nar_rvalid = 0, nar_err = 0;
  logic [31:0] nar_rdata = 0;
  logic wid_ready = 1, wid_rvalid = 0, wid_err = 0;
  logic [63:0] wid_rdata = 0;

  dev_aware_splitter uut (.*);

  int tests = 0, fails = 0;
  int lat = 1; logic stall = 0; logic [31:0] err_addr = 32'hFFFF_FFFF;
  int nlog = 0, nwide = 0, r4_bad = 0, r10_bad = 0, ncnt = 0, wcnt = 0;
  logic [31:0] log_addr [0:7]; logic [1:0] log_size [0:7], log_mt [0:7];
  logic [3:0]  log_strb [0:7]; logic [31:0] log_wd [0:7]; logic log_wr [0:7];
  logic [31:0] rd_addr = 0, wa = 0, prev_addr = 0, prev_wd = 0;
  logic rd_wr = 0, pend = 0, prev_wait = 0; logic [3:0] prev_strb = 0;

  function automatic logic [31:0] mword(logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  // Narrow and wide memory models
  always @(posedge clk) begin
    nar_rvalid <= 0; wid_rvalid <= 0;
    if (ncnt != 0) begin
      ncnt <= ncnt - 1;
      if (ncnt == 1) begin
        nar_rvalid <= 1; nar_rdata <= rd_wr ? 32'h0 : mword(rd_addr);
        nar_err <= (rd_addr == err_addr); pend <= 0;
      end
    end
    if (nar_valid && nar_ready) begin
      if (pend) r4_bad++;
      if (nlog < 8) begin
        log_addr[nlog] = nar_addr; log_size[nlog] = nar_size; log_mt[nlog] = nar_mtype;
        log_strb[nlog] = nar_strb; log_wd[nlog] = nar_wdata; log_wr[nlog] = nar_write;
      end
      nlog++; pend <= 1; ncnt <= lat; rd_addr <= nar_addr; rd_wr <= nar_write;
    end
    if (prev_wait && (nar_addr != prev_addr || nar_wdata != prev_wd || nar_strb != prev_strb))
      r10_bad++;
    prev_wait <= nar_valid && !nar_ready;
    prev_addr <= nar_addr; prev_wd <= nar_wdata; prev_strb <= nar_strb;
    nar_ready <= stall ? ~nar_ready : 1'b1;
    if (wcnt != 0) begin
      wcnt <= wcnt - 1;
      if (wcnt == 1) begin
        wid_rvalid <= 1; wid_err <= (wa == err_addr);
        wid_rdata <= wid_write ? 64'h0 : {mword(wa + 32'd4), mword(wa)};
      end
    end
    if (wid_valid && wid_ready) begin nwide++; wa <= wid_addr; wcnt <= lat; end
  end

  task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
  endtask

  localparam int NV = 8;
  localparam logic [31:0] T_ADDR [NV] = '{32'h1000, 32'h2008, 32'h3004, 32'h3001,
                                          32'h4000, 32'h5006, 32'h6000, 32'h7000};
  localparam logic        T_WR   [NV] = '{0, 1, 0, 1, 0, 1, 1, 0};
  localparam logic [1:0]  T_SIZE [NV] = '{3, 3, 2, 0, 3, 1, 3, 3};
  localparam logic [7:0]  T_STRB [NV] = '{8'hFF, 8'hF0, 8'hF0, 8'h02, 8'hFF, 8'hC0, 8'h3C, 8'hFF};
  localparam logic [63:0] T_WD   [NV] = '{64'h0, 64'h1122_3344_5566_7788, 64'h0, 64'h0000_0000_0000_AB00,
                                          64'h0, 64'hDEAD_0000_0000_0000, 64'h0102_0304_0506_0708, 64'h0};
  localparam logic [1:0]  T_MT   [NV] = '{1, 2, 1, 0, 0, 2, 0, 1};
  localparam logic [31:0] T_ERR  [NV] = '{32'hFFFF_FFFF, 32'h200C, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                          32'h4000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h7000};
  localparam int          T_LAT  [NV] = '{1, 1, 2, 1, 1, 3, 2, 3};
  localparam logic        T_STL  [NV] = '{0, 0, 0, 1, 0, 1, 0, 1};
  localparam int          T_BEATS[NV] = '{2, 2, 1, 1, 0, 1, 0, 2};
  localparam logic        T_EERR [NV] = '{0, 1, 0, 0, 1, 0, 0, 1};

  task automatic send(input logic [31:0] a, input logic w, input logic [1:0] s,
                      input logic [7:0] st, input logic [63:0] d, input logic [1:0] m);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w; req_size = s;
    req_strb = st; req_wdata = d; req_mtype = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 0;
  endtask

  task automatic run_vec(input int i);
    logic dw, hi; logic [31:0] ea; logic [63:0] erd; string rq;
    lat = T_LAT[i]; stall = T_STL[i]; err_addr = T_ERR[i]; nlog = 0; nwide = 0;
    send(T_ADDR[i], T_WR[i], T_SIZE[i], T_STRB[i], T_WD[i], T_MT[i]);
    while (!rsp_valid) @(negedge clk);
    dw = T_SIZE[i] == 2'd3;
    rq = dw ? "R3" : "R2";
    chk(nlog == T_BEATS[i], dw ? "R3 beat count" : "R2 beat count", nlog, T_BEATS[i]);
    chk(nwide == ((T_BEATS[i] == 0) ? 1 : 0), "R8 wide beat count", nwide, (T_BEATS[i] == 0));
    for (int k = 0; k < T_BEATS[i] && k < nlog; k++) begin
      hi = dw ? k[0] : T_ADDR[i][2];
      ea = dw ? {T_ADDR[i][31:3], hi, 2'b00} : T_ADDR[i];
      chk(log_addr[k] == ea && log_size[k] == (dw ? 2'd2 : T_SIZE[i]) && log_wr[k] == T_WR[i],
          {rq, " addr/size order"}, {log_addr[k], log_size[k]}, {ea, (dw ? 2'd2 : T_SIZE[i])});
      chk(log_strb[k] == (hi ? T_STRB[i][7:4] : T_STRB[i][3:0]) &&
          log_wd[k] == (hi ? T_WD[i][63:32] : T_WD[i][31:0]),
          {rq, " lane strb/data"}, {log_strb[k], log_wd[k]},
          {(hi ? T_STRB[i][7:4] : T_STRB[i][3:0]), (hi ? T_WD[i][63:32] : T_WD[i][31:0])});
      chk(log_mt[k] == T_MT[i], "R7 mtype forwarded", log_mt[k], T_MT[i]);
    end
    if (T_WR[i]) erd = 64'h0;
    else if (dw) erd = {mword({T_ADDR[i][31:3], 3'b100}), mword({T_ADDR[i][31:3], 3'b000})};
    else erd = T_ADDR[i][2] ? {mword(T_ADDR[i]), 32'h0} : {32'h0, mword(T_ADDR[i])};
    chk(rsp_rdata == erd, T_BEATS[i] == 0 ? "R8 wide rdata" : "R5 merged rdata", rsp_rdata, erd);
    chk(rsp_err == T_EERR[i], "R6 combined err", rsp_err, T_EERR[i]);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R9 watchdog expired act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [63:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !nar_valid && !wid_valid && !rsp_valid, "R1 reset state",
        {req_ready, nar_valid, wid_valid, rsp_valid}, 4'b1000);
    for (int i = 0; i < NV; i++) run_vec(i);
    chk(r4_bad == 0, "R4 beat before response", r4_bad, 0);
    chk(r10_bad == 0, "R10 stalled beat changed", r10_bad, 0);
    // R9: response held while rsp_ready is low, no new request accepted
    lat = 1; stall = 0; err_addr = 32'hFFFF_FFFF; rsp_ready = 0;
    send(32'hA004, 0, 2'd2, 8'hF0, 64'h0, 2'd1);
    while (!rsp_valid) @(negedge clk);
    held = rsp_rdata;
    repeat (3) @(negedge clk);
    chk(rsp_valid && !req_ready, "R9 held response", {rsp_valid, req_ready}, 2'b10);
    chk(rsp_rdata == held && held == {mword(32'hA004), 32'h0}, "R9 stable rdata", rsp_rdata,
        {mword(32'hA004), 32'h0});
    rsp_ready = 1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R9 release", {rsp_valid, req_ready}, 2'b01);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule